// File: doc/BRIEF.md
# Indexed Register Window for an I/O Interrupt Router

This block holds the register state of an I/O interrupt router and exposes it through two locations on a 32-bit register bus. An index location holds an 8-bit pointer. A data window then reads or writes whichever internal register that pointer selects. Behind the window sit a 4-bit router ID, a read-only version word, and one 64-bit routing entry per input pin. Each routing entry is reached as two 32-bit halves. A third bus location accepts an end-of-interrupt vector. Only the newer version code honours it, and only for full 4-byte writes.

Each routing entry holds two status bits that software cannot write. One is the delivery-busy bit, which is copied from a per-pin input. The other is the remote-pending bit. It is set by a per-pin pulse while the entry is level-triggered. It is cleared by an end-of-interrupt whose vector matches the entry. It is also cleared by any write that leaves the entry edge-triggered. The whole table is driven out flat so that neighbouring pin-sampling and message logic can decode it. Accepted end-of-interrupt writes also appear as a one-cycle strobe that carries the vector.

Top module: `ioc_regfile`

## Requirements
- R1: After reset the index register and the ID are zero. Every routing entry reads 0x0000_0000_0001_0000, with only the mask bit (bit 16) set.
- R2: Bus offset 0x00 reads and writes the 8-bit index in bits [7:0]. Offset 0x10 is the data window. Offset 0x40 is the end-of-interrupt location. Every other offset, including 0x40, reads as zero.
- R3: Index 0x10+2n selects the low half of entry n, and index 0x11+2n selects its high half. A window write changes only that half. Index values from 0x02 to 0x0F, and values at or above 0x10+2*NUM_PINS, read as zero and ignore writes.
- R4: Index 0x00 is the ID register. A write stores data bits [27:24], and a read returns them in bits [27:24] with all other bits zero.
- R5: Index 0x01 reads the version code in bits [7:0] and NUM_PINS-1 in bits [23:16]. Writes to it have no effect. The only valid codes are 0x11 and 0x20, and any other parameter value behaves as 0x20.
- R6: In each entry, bit 12 (delivery busy) shows the pin's busy input from the previous cycle. Bit 14 (remote pending) is changed only by hardware events. Bus writes never change either bit.
- R7: A remote-pending set pulse on a pin sets bit 14 only while that entry's trigger bit (bit 15) is 1, meaning level. When bit 15 is 0, the pulse is ignored.
- R8: A write to either half of an entry that leaves bit 15 at 0 (edge) clears bit 14 in the same cycle.
- R9: A bus write to offset 0x40 with size 4 produces, in the next cycle, a one-cycle strobe with data bits [7:0] as the vector. This happens only when the version is 0x20. Other sizes, or version 0x11, produce no strobe.
- R10: An accepted end-of-interrupt clears bit 14 of every entry whose vector field (bits [7:0]) equals the written vector. It leaves other entries untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus byte offset |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_busy | input | NUM_PINS | Per-pin delivery busy status |
| pin_rirr_set | input | NUM_PINS | Per-pin remote-pending set pulse |
| tbl_flat | output | NUM_PINS*64 | All routing entries, entry n at bits [64n+63:64n] |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | Vector carried by the strobe |

## Verification
The bound checker watches the status bits in every cycle. It checks that the busy bit always mirrors the previous cycle's input, and that an edge-triggered entry never holds a remote-pending bit. It also checks that remote-pending only rises after a set pulse, and that every strobe traces back to a 4-byte write at the end-of-interrupt offset carrying the same vector. The index decoding, the survival of the status bits across writes that try to change them, the gating of end-of-interrupt by size and version, and the matching of vectors against entries can only be shown by the bench's scenarios. For these, the bench reads registers back through the window and compares the two version instances side by side.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    localparam int unsigned REG_W = 32;

    localparam logic [7:0] OFS_INDEX  = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] OFS_EOI    = 8'h40;

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_TBL = 8'h10;

    localparam int unsigned B_DS   = 12;
    localparam int unsigned B_RIRR = 14;
    localparam int unsigned B_TRIG = 15;
    localparam int unsigned B_MASK = 16;

    localparam logic [63:0] ENTRY_RST = 64'h1 << B_MASK;
    localparam logic [63:0] RO_MASK   = (64'h1 << B_DS) | (64'h1 << B_RIRR);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ID,
        SEL_VER,
        SEL_TBL
    } win_sel_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] vec;
    } eoi_t;

    function automatic logic [7:0] pick_version(input logic [7:0] code);
        return (code == 8'h11) ? 8'h11 : 8'h20;
    endfunction

    function automatic logic [31:0] ver_word(input logic [7:0] code, input int unsigned pins);
        return {8'h00, 8'(pins - 1), 8'h00, code};
    endfunction

endpackage

// File: rtl/ioc_decode.sv
module ioc_decode
    import ioc_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [7:0]             index_q,
    input  logic [3:0]             id_q,
    input  logic [31:0]            ver_word_i,
    input  logic [NUM_PINS*64-1:0] tbl_flat,
    output logic                   idx_we,
    output logic                   id_we,
    output logic                   eoi_hit,
    output logic [NUM_PINS-1:0]    ent_wr_lo,
    output logic [NUM_PINS-1:0]    ent_wr_hi,
    output logic [REG_W-1:0]       rdata
);

    localparam logic [8:0] TBL_END = 9'(int'(IDX_TBL) + 2 * NUM_PINS);

    logic     at_index;
    logic     at_window;
    logic     at_eoi;
    logic     in_tbl;
    logic     win_we;
    logic [7:0] ent_num;
    win_sel_e win_sel;
    logic [REG_W-1:0] win_data;
    int       rd_off;

    assign at_index  = (bus_addr == ADDR_W'(OFS_INDEX));
    assign at_window = (bus_addr == ADDR_W'(OFS_WINDOW));
    assign at_eoi    = (bus_addr == ADDR_W'(OFS_EOI));
    assign in_tbl    = (index_q >= IDX_TBL) && ({1'b0, index_q} < TBL_END);
    assign ent_num   = (index_q - IDX_TBL) >> 1;
    assign win_we    = bus_we && at_window;

    assign idx_we  = bus_we && at_index;
    assign eoi_hit = bus_we && at_eoi;

    always_comb begin
        if (index_q == IDX_ID)       win_sel = SEL_ID;
        else if (index_q == IDX_VER) win_sel = SEL_VER;
        else if (in_tbl)             win_sel = SEL_TBL;
        else                         win_sel = SEL_NONE;
    end

    assign id_we = win_we && (win_sel == SEL_ID);

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_wr
            assign ent_wr_lo[p] = win_we && in_tbl && (ent_num == 8'(p)) && !index_q[0];
            assign ent_wr_hi[p] = win_we && in_tbl && (ent_num == 8'(p)) &&  index_q[0];
        end
    endgenerate

    always_comb begin
        rd_off = in_tbl ? (int'(ent_num) * 64 + int'(index_q[0]) * 32) : 0;
        case (win_sel)
            SEL_ID:  win_data = {4'h0, id_q, 24'h0};
            SEL_VER: win_data = ver_word_i;
            SEL_TBL: win_data = tbl_flat[rd_off +: 32];
            default: win_data = '0;
        endcase
    end

    always_comb begin
        if (at_index)       rdata = {24'h0, index_q};
        else if (at_window) rdata = win_data;
        else                rdata = '0;
    end

endmodule

// File: rtl/ioc_entry.sv
module ioc_entry
    import ioc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        busy,
    input  logic        rirr_set,
    input  logic        eoi_fire,
    input  logic [7:0]  eoi_vec,
    output logic [63:0] entry_o
);

    logic [63:0] rw_q;
    logic [63:0] rw_d;
    logic        ds_q;
    logic        rirr_q;
    logic        rirr_d;
    logic        written;
    logic        eoi_match;

    always_comb begin
        rw_d = rw_q;
        if (wr_lo) rw_d[31:0]  = wdata;
        if (wr_hi) rw_d[63:32] = wdata;
        rw_d = rw_d & ~RO_MASK;
    end

    assign written   = wr_lo || wr_hi;
    assign eoi_match = eoi_fire && (rw_q[7:0] == eoi_vec);

    always_comb begin
        rirr_d = rirr_q;
        if (rirr_set && rw_q[B_TRIG]) rirr_d = 1'b1;
        if (eoi_match)                rirr_d = 1'b0;
        if (written && !rw_d[B_TRIG]) rirr_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rw_q   <= ENTRY_RST;
            ds_q   <= 1'b0;
            rirr_q <= 1'b0;
        end else begin
            rw_q   <= rw_d;
            ds_q   <= busy;
            rirr_q <= rirr_d;
        end
    end

    always_comb begin
        entry_o         = rw_q;
        entry_o[B_DS]   = ds_q;
        entry_o[B_RIRR] = rirr_q;
    end

endmodule

// File: rtl/ioc_eoi.sv
module ioc_eoi
    import ioc_pkg::*;
#(
    parameter logic [7:0] VER_CODE = 8'h20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hit,
    input  logic [2:0]  size,
    input  logic [31:0] wdata,
    output logic        fire,
    output eoi_t        eoi_o
);

    generate
        if (VER_CODE == 8'h20) begin : g_on
            assign fire = hit && (size == 3'd4);
        end else begin : g_off
            assign fire = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            eoi_o <= '0;
        end else begin
            eoi_o.valid <= fire;
            eoi_o.vec   <= fire ? wdata[7:0] : 8'h00;
        end
    end

endmodule

// File: rtl/ioc_regfile.sv
module ioc_regfile
    import ioc_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [7:0]  VER_CODE = 8'h20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [2:0]             bus_size,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]    pin_busy,
    input  logic [NUM_PINS-1:0]    pin_rirr_set,
    output logic [NUM_PINS*64-1:0] tbl_flat,
    output logic                   eoi_valid,
    output logic [7:0]             eoi_vector
);

    localparam logic [7:0]  VER_EFF  = pick_version(VER_CODE);
    localparam logic [31:0] VER_WORD = ver_word(VER_EFF, NUM_PINS);

    logic [7:0]          index_q;
    logic [3:0]          id_q;
    logic                idx_we;
    logic                id_we;
    logic                eoi_hit;
    logic                eoi_fire;
    logic [NUM_PINS-1:0] ent_wr_lo;
    logic [NUM_PINS-1:0] ent_wr_hi;
    eoi_t                eoi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
            id_q    <= 4'h0;
        end else begin
            if (idx_we) index_q <= bus_wdata[7:0];
            if (id_we)  id_q    <= bus_wdata[27:24];
        end
    end

    ioc_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .index_q   (index_q),
        .id_q      (id_q),
        .ver_word_i(VER_WORD),
        .tbl_flat  (tbl_flat),
        .idx_we    (idx_we),
        .id_we     (id_we),
        .eoi_hit   (eoi_hit),
        .ent_wr_lo (ent_wr_lo),
        .ent_wr_hi (ent_wr_hi),
        .rdata     (bus_rdata)
    );

    ioc_eoi #(.VER_CODE(VER_EFF)) u_eoi (
        .clk  (clk),
        .rst  (rst),
        .hit  (eoi_hit),
        .size (bus_size),
        .wdata(bus_wdata),
        .fire (eoi_fire),
        .eoi_o(eoi_q)
    );

    assign eoi_valid  = eoi_q.valid;
    assign eoi_vector = eoi_q.vec;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
            ioc_entry u_ent (
                .clk     (clk),
                .rst     (rst),
                .wr_lo   (ent_wr_lo[p]),
                .wr_hi   (ent_wr_hi[p]),
                .wdata   (bus_wdata),
                .busy    (pin_busy[p]),
                .rirr_set(pin_rirr_set[p]),
                .eoi_fire(eoi_fire),
                .eoi_vec (bus_wdata[7:0]),
                .entry_o (tbl_flat[p*64 +: 64])
            );
        end
    endgenerate

endmodule

module ioc_regfile_chk
    import ioc_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned ADDR_W   = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [2:0]             bus_size,
    input logic [31:0]            bus_wdata,
    input logic [NUM_PINS-1:0]    pin_busy,
    input logic [NUM_PINS-1:0]    pin_rirr_set,
    input logic [NUM_PINS*64-1:0] tbl_flat,
    input logic                   eoi_valid,
    input logic [7:0]             eoi_vector
);

    AST_EOI_SOURCE: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> $past(bus_we && bus_addr == ADDR_W'(OFS_EOI) && bus_size == 3'd4)); // R9

    AST_EOI_VECTOR: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> eoi_vector == $past(bus_wdata[7:0])); // R9

    AST_EOI_SIZE_GATE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(OFS_EOI) && bus_size != 3'd4) |=> !eoi_valid); // R9

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> tbl_flat[p*64 + B_DS] == $past(pin_busy[p])); // R6

            AST_EDGE_NO_PEND: assert property (@(posedge clk) disable iff (rst)
                !tbl_flat[p*64 + B_TRIG] |-> !tbl_flat[p*64 + B_RIRR]); // R8

            AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
                $rose(tbl_flat[p*64 + B_RIRR]) |-> $past(pin_rirr_set[p])); // R7
        end
    endgenerate

endmodule

bind ioc_regfile ioc_regfile_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .pin_busy    (pin_busy),
    .pin_rirr_set(pin_rirr_set),
    .tbl_flat    (tbl_flat),
    .eoi_valid   (eoi_valid),
    .eoi_vector  (eoi_vector)
);

// File: tb/ioc_regfile_tb.sv
module ioc_regfile_tb;

    localparam int unsigned NP = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        bus_addr = 8'h00;
    logic              bus_we = 1'b0;
    logic [2:0]        bus_size = 3'd4;
    logic [31:0]       bus_wdata = 32'h0;
    logic [31:0]       bus_rdata;
    logic [31:0]       rdata_b;
    logic [NP-1:0]     pin_busy = '0;
    logic [NP-1:0]     pin_rirr_set = '0;
    logic [NP*64-1:0]  tbl_flat;
    logic [NP*64-1:0]  tbl_b;
    logic              eoi_valid, eoi_valid_b;
    logic [7:0]        eoi_vector, eoi_vector_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ioc_regfile #(.NUM_PINS(NP), .ADDR_W(8), .VER_CODE(8'h20)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_busy(pin_busy),
        .pin_rirr_set(pin_rirr_set), .tbl_flat(tbl_flat), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector)
    );

    ioc_regfile #(.NUM_PINS(NP), .ADDR_W(8), .VER_CODE(8'h11)) u_dut_v11 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_busy(pin_busy),
        .pin_rirr_set(pin_rirr_set), .tbl_flat(tbl_b), .eoi_valid(eoi_valid_b),
        .eoi_vector(eoi_vector_b)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz = 3'd4);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_size = 3'd4;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic rd_win(input logic [7:0] idx, output logic [31:0] d);
        wr(8'h00, {24'h0, idx});
        rd(8'h10, d);
    endtask

    task automatic pulse_pend(input int p);
        @(negedge clk);
        pin_rirr_set[p] = 1'b1;
        @(negedge clk);
        pin_rirr_set[p] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bit ok = 1'b1;
        for (int p = 0; p < NP; p++)
            if (tbl_flat[p*64 +: 64] !== 64'h0000_0000_0001_0000) ok = 1'b0;
        chk("R1 all entries masked", 64'(ok), 64'd1);
        rd(8'h00, d);   chk("R1 index zero", 64'(d), 64'h0);
        rd(8'h10, d);   chk("R1 id zero", 64'(d), 64'h0);
        rd_win(8'h10, d); chk("R1 entry0 low", 64'(d), 64'h0001_0000);
        rd_win(8'h11, d); chk("R1 entry0 high", 64'(d), 64'h0);
    endtask

    task automatic t_id_version();
        logic [31:0] d;
        wr(8'h00, 32'h0000_0000);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R4 id field", 64'(d), 64'h0F00_0000);
        wr(8'h00, 32'h0000_0001);
        rd(8'h10, d); chk("R5 version v20", 64'(d), 64'h0017_0020);
        chk("R5 version v11", 64'(rdata_b), 64'h0017_0011);
        wr(8'h10, 32'h1234_5678);
        rd(8'h10, d); chk("R5 version write ignored", 64'(d), 64'h0017_0020);
        rd(8'h00, d); chk("R2 index readback", 64'(d), 64'h01);
        rd(8'h20, d); chk("R2 unused offset reads zero", 64'(d), 64'h0);
    endtask

    task automatic t_entry_rw();
        logic [31:0] d;
        wr(8'h00, 32'h1A);
        wr(8'h10, 32'h0000_A0B3);
        wr(8'h00, 32'h1B);
        wr(8'h10, 32'hFF00_0000);
        rd_win(8'h1A, d); chk("R3 entry5 low", 64'(d), 64'h0000_A0B3);
        rd_win(8'h1B, d); chk("R3 entry5 high", 64'(d), 64'hFF00_0000);
        chk("R3 entry5 flat", tbl_flat[5*64 +: 64], 64'hFF00_0000_0000_A0B3);
        chk("R3 entry4 untouched", tbl_flat[4*64 +: 64], 64'h0000_0000_0001_0000);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        wr(8'h00, 32'h40);
        wr(8'h10, 32'h1234_5678);
        rd(8'h10, d); chk("R3 index past table reads zero", 64'(d), 64'h0);
        rd_win(8'h3E, d); chk("R3 last entry low intact", 64'(d), 64'h0001_0000);
        rd_win(8'h3F, d); chk("R3 last entry high intact", 64'(d), 64'h0);
        wr(8'h00, 32'h05);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R3 gap index reads zero", 64'(d), 64'h0);
        wr(8'h00, 32'h00);
        rd(8'h10, d); chk("R3 gap write left id", 64'(d), 64'h0F00_0000);
    endtask

    task automatic t_ro_bits();
        logic [31:0] d;
        @(negedge clk); pin_busy[5] = 1'b1;
        pulse_pend(5);
        rd_win(8'h1A, d); chk("R6 R7 busy and pending set", 64'(d), 64'h0000_F0B3);
        wr(8'h10, 32'h0000_A0B3);
        rd(8'h10, d); chk("R6 write keeps status bits", 64'(d), 64'h0000_F0B3);
        wr(8'h00, 32'h1C);
        wr(8'h10, 32'h0000_5000);
        rd(8'h10, d); chk("R6 write cannot set status bits", 64'(d), 64'h0);
    endtask

    task automatic t_eoi();
        logic [31:0] d;
        wr(8'h40, 32'h0000_00B3, 3'd2);
        chk("R9 size 2 no strobe", 64'(eoi_valid), 64'd0);
        chk("R10 size 2 keeps pending", 64'(tbl_flat[5*64 + 14]), 64'd1);
        wr(8'h40, 32'h0000_0022);
        chk("R9 strobe on 4-byte write", 64'(eoi_valid), 64'd1);
        chk("R9 strobe vector", 64'(eoi_vector), 64'h22);
        chk("R10 other vector keeps pending", 64'(tbl_flat[5*64 + 14]), 64'd1);
        wr(8'h40, 32'h0000_00B3);
        chk("R9 strobe vector match", 64'(eoi_vector), 64'hB3);
        chk("R9 v11 no strobe", 64'(eoi_valid_b), 64'd0);
        chk("R10 matching vector clears", 64'(tbl_flat[5*64 + 14]), 64'd0);
        chk("R10 v11 pending kept", 64'(tbl_b[5*64 + 14]), 64'd1);
        rd(8'h40, d); chk("R2 eoi offset reads zero", 64'(d), 64'h0);
        @(negedge clk); #1;
        chk("R9 strobe lasts one cycle", 64'(eoi_valid), 64'd0);
    endtask

    task automatic t_edge_fix();
        logic [31:0] d;
        pulse_pend(5);
        chk("R7 pending set again", 64'(tbl_flat[5*64 + 14]), 64'd1);
        wr(8'h00, 32'h1A);
        wr(8'h10, 32'h0000_20B3);
        rd(8'h10, d); chk("R8 edge write clears pending", 64'(d), 64'h0000_30B3);
        pulse_pend(5);
        rd(8'h10, d); chk("R7 set ignored in edge mode", 64'(d), 64'h0000_30B3);
        @(negedge clk); pin_busy[5] = 1'b0;
        @(negedge clk);
        rd(8'h10, d); chk("R6 busy follows input", 64'(d), 64'h0000_20B3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_id_version();
        t_entry_rw();
        t_out_of_range();
        t_ro_bits();
        t_eoi();
        t_edge_fix();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule